// File: doc/BRIEF.md
# Hysteresis Current Controller for a Two-Cable Series Flow Regulator

This block is the digital gating controller for a series regulator that shares one capacitor between two cables. It receives signed fixed-point samples of the two cable currents, together with a sample-valid strobe. It also receives a function select and an external reference. From these inputs it drives four switch gates.

On every strobe the block does three things:
- It forms a current reference. In balancing this is the floor of the mean of the two currents. In set-point it is the external value. In nulling it is zero.
- It picks the operating mode from whichever cable carries more current.
- It runs a hysteresis comparator on the current of the selected cable.

The comparator's charge/discharge decision is then mapped onto the gate pattern of the selected mode. The band half-width comes from an unsigned input in the same fixed-point format as the currents.

The mode is only re-chosen while the comparator is in the charging phase. This keeps the gate mapping fixed for the whole of a discharge interval. When the block is disabled, every gate is low and the comparator goes back to charging.

Top module: `hcc_gate_ctrl`

## Requirements
- R1: While `en` is low, all four gates are low one clock later and the comparator returns to charging. The mode is kept. Reset gives all gates low, charging, and mode A.
- R2: On a strobe taken in the charging phase, `cur_a > cur_b` selects mode A and `cur_b > cur_a` selects mode B. Equal currents keep the previous mode.
- R3: With `func_sel` = 0 (balance), the reference is floor((cur_a + cur_b) / 2), computed without overflow.
- R4: With `func_sel` = 1 (set-point), the reference is `ext_ref`. With `func_sel` = 2 or 3 (null), the reference is zero and `ext_ref` has no effect.
- R5: In the charging phase, a strobe whose controlled current is less than or equal to reference minus `band` moves the comparator to discharging. The controlled current is `cur_a` in mode A and `cur_b` in mode B.
- R6: In the discharging phase, a strobe whose controlled current is strictly greater than reference plus `band` returns the comparator to charging. Otherwise the comparator holds its state, and a band of zero makes it a plain comparator.
- R7: The gate pattern, written as {sa1, sa2, sb1, sb2}, depends on mode and phase:
  - charging in mode A gives 0100;
  - charging in mode B gives 1000;
  - discharging gives 0011 in either mode;
  - no other non-zero pattern ever appears.
- R8: The mode cannot change while the comparator is discharging. This includes the strobe that ends the discharge, whose charging pattern uses the mode held through the discharge.
- R9: Gate outputs are registered and change only on the clock edge that samples `en` and `smp_vld` both high. Without a strobe they hold.
- R10: In null, a controlled current above minus `band` keeps the comparator charging, so the capacitor stays in series with the cable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Controller enable; low forces all gates off |
| smp_vld | input | 1 | Sample strobe for the current inputs |
| cur_a | input | CUR_W | Signed current of cable A |
| cur_b | input | CUR_W | Signed current of cable B |
| func_sel | input | 2 | 0 balance, 1 set-point, 2 or 3 null |
| ext_ref | input | CUR_W | Signed external reference for set-point |
| band | input | CUR_W | Unsigned hysteresis half-width |
| gate_sa1 | output | 1 | Shunt switch gate, driven in mode B charging |
| gate_sa2 | output | 1 | Shunt switch gate, driven in mode A charging |
| gate_sb1 | output | 1 | Series switch gate, driven while discharging |
| gate_sb2 | output | 1 | Series switch gate, driven while discharging |

## Verification
The assertions take for granted that `en`, `smp_vld` and `func_sel` are always known, and that the currents, `ext_ref` and `band` are valid whenever a strobe is taken. The stimulus changes every input only on the falling edge and raises `smp_vld` for exactly one clock per sample, so each strobe is sampled once. Currents, references and band stay far inside the 8-bit range used by the bench. No case therefore depends on saturation, which the design does not have; the widened arithmetic is checked only for exactness.

// File: rtl/hcc_pkg.sv
`timescale 1ns/1ps
package hcc_pkg;

  typedef enum logic [1:0] {
    FN_BAL   = 2'd0,
    FN_SET   = 2'd1,
    FN_NULL  = 2'd2,
    FN_NULL2 = 2'd3
  } fn_e;

  typedef enum logic {
    MODE_A = 1'b0,
    MODE_B = 1'b1
  } mode_e;

  typedef enum logic {
    PH_CHARGE = 1'b0,
    PH_DISCH  = 1'b1
  } phase_e;

  typedef struct packed {
    logic sa1;
    logic sa2;
    logic sb1;
    logic sb2;
  } gate_t;

  // Switch pattern for a mode/phase pair
  function automatic gate_t gate_pattern(mode_e m, phase_e p);
    gate_t g;
    g = '0;
    if (p == PH_DISCH) begin
      g.sb1 = 1'b1;
      g.sb2 = 1'b1;
    end else if (m == MODE_A) begin
      g.sa2 = 1'b1;
    end else begin
      g.sa1 = 1'b1;
    end
    return g;
  endfunction

endpackage

// File: rtl/hcc_ref_gen.sv
`timescale 1ns/1ps
module hcc_ref_gen
  import hcc_pkg::*;
#(
  parameter int CUR_W = 16
) (
  input  logic signed [CUR_W-1:0] cur_a,
  input  logic signed [CUR_W-1:0] cur_b,
  input  logic        [1:0]       func_sel,
  input  logic signed [CUR_W-1:0] ext_ref,
  output logic signed [CUR_W-1:0] ref_o
);
  localparam int SW = CUR_W + 1;

  // Floor of the mean: widen, add, arithmetic shift right by one
  function automatic logic signed [CUR_W-1:0] floor_mean(
    logic signed [CUR_W-1:0] x, logic signed [CUR_W-1:0] y);
    logic signed [SW-1:0] s;
    s = SW'(x) + SW'(y);
    return s[SW-1:1];
  endfunction

  always_comb begin
    unique case (fn_e'(func_sel))
      FN_BAL:  ref_o = floor_mean(cur_a, cur_b);
      FN_SET:  ref_o = ext_ref;
      default: ref_o = '0;
    endcase
  end
endmodule

// File: rtl/hcc_mode_sel.sv
`timescale 1ns/1ps
module hcc_mode_sel
  import hcc_pkg::*;
#(
  parameter int CUR_W = 16
) (
  input  logic signed [CUR_W-1:0] cur_a,
  input  logic signed [CUR_W-1:0] cur_b,
  input  mode_e                   mode_q,
  input  phase_e                  phase_q,
  output mode_e                   mode_nxt,
  output logic signed [CUR_W-1:0] ctrl_o
);
  logic a_above;
  logic b_above;

  assign a_above = cur_a > cur_b;
  assign b_above = cur_b > cur_a;

  always_comb begin
    mode_nxt = mode_q;
    if (phase_q == PH_CHARGE) begin
      if (a_above)      mode_nxt = MODE_A;
      else if (b_above) mode_nxt = MODE_B;
    end
  end

  assign ctrl_o = (mode_nxt == MODE_A) ? cur_a : cur_b;
endmodule

// File: rtl/hcc_band_cmp.sv
`timescale 1ns/1ps
module hcc_band_cmp
  import hcc_pkg::*;
#(
  parameter int CUR_W = 16
) (
  input  logic signed [CUR_W-1:0] ctrl_i,
  input  logic signed [CUR_W-1:0] ref_i,
  input  logic        [CUR_W-1:0] band,
  input  phase_e                  phase_q,
  output phase_e                  phase_nxt,
  output logic                    hit_lo,
  output logic                    hit_hi
);
  localparam int EW = CUR_W + 2;

  function automatic logic signed [EW-1:0] widen_s(logic signed [CUR_W-1:0] v);
    return EW'(v);
  endfunction

  function automatic logic signed [EW-1:0] widen_u(logic [CUR_W-1:0] v);
    return signed'({2'b00, v});
  endfunction

  logic signed [EW-1:0] edge_lo;
  logic signed [EW-1:0] edge_hi;

  assign edge_lo = widen_s(ref_i) - widen_u(band);
  assign edge_hi = widen_s(ref_i) + widen_u(band);
  assign hit_lo  = widen_s(ctrl_i) <= edge_lo;
  assign hit_hi  = widen_s(ctrl_i) >  edge_hi;

  always_comb begin
    phase_nxt = phase_q;
    if (phase_q == PH_CHARGE) begin
      if (hit_lo) phase_nxt = PH_DISCH;
    end else begin
      if (hit_hi) phase_nxt = PH_CHARGE;
    end
  end
endmodule

// File: rtl/hcc_gate_ctrl.sv
`timescale 1ns/1ps
module hcc_gate_ctrl
  import hcc_pkg::*;
#(
  parameter int CUR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    smp_vld,
  input  logic signed [CUR_W-1:0] cur_a,
  input  logic signed [CUR_W-1:0] cur_b,
  input  logic        [1:0]       func_sel,
  input  logic signed [CUR_W-1:0] ext_ref,
  input  logic        [CUR_W-1:0] band,
  output logic                    gate_sa1,
  output logic                    gate_sa2,
  output logic                    gate_sb1,
  output logic                    gate_sb2
);
  mode_e  mode_q;
  mode_e  mode_nxt;
  phase_e phase_q;
  phase_e phase_nxt;
  gate_t  gates_q;
  gate_t  gate_nxt;

  // Named internal events for the checker
  logic signed [CUR_W-1:0] ref_w;
  logic signed [CUR_W-1:0] ctrl_w;
  logic                    hit_lo;
  logic                    hit_hi;
  logic                    take;

  assign take = en & smp_vld;

  hcc_ref_gen #(.CUR_W(CUR_W)) u_ref (
    .cur_a    (cur_a),
    .cur_b    (cur_b),
    .func_sel (func_sel),
    .ext_ref  (ext_ref),
    .ref_o    (ref_w)
  );

  hcc_mode_sel #(.CUR_W(CUR_W)) u_mode (
    .cur_a    (cur_a),
    .cur_b    (cur_b),
    .mode_q   (mode_q),
    .phase_q  (phase_q),
    .mode_nxt (mode_nxt),
    .ctrl_o   (ctrl_w)
  );

  hcc_band_cmp #(.CUR_W(CUR_W)) u_cmp (
    .ctrl_i    (ctrl_w),
    .ref_i     (ref_w),
    .band      (band),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .hit_lo    (hit_lo),
    .hit_hi    (hit_hi)
  );

  assign gate_nxt = gate_pattern(mode_nxt, phase_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_A;
      phase_q <= PH_CHARGE;
      gates_q <= '0;
    end else if (!en) begin
      phase_q <= PH_CHARGE;
      gates_q <= '0;
    end else if (take) begin
      mode_q  <= mode_nxt;
      phase_q <= phase_nxt;
      gates_q <= gate_nxt;
    end
  end

  assign gate_sa1 = gates_q.sa1;
  assign gate_sa2 = gates_q.sa2;
  assign gate_sb1 = gates_q.sb1;
  assign gate_sb2 = gates_q.sb2;
endmodule

// File: rtl/hcc_gate_ctrl_chk.sv
`timescale 1ns/1ps
module hcc_gate_ctrl_chk #(
  parameter int CUR_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic                    smp_vld,
  input logic signed [CUR_W-1:0] cur_a,
  input logic signed [CUR_W-1:0] cur_b,
  input logic        [1:0]       func_sel,
  input logic signed [CUR_W-1:0] ref_w,
  input logic                    hit_lo,
  input logic                    mode_q,
  input logic                    phase_q,
  input logic                    gate_sa1,
  input logic                    gate_sa2,
  input logic                    gate_sb1,
  input logic                    gate_sb2
);
  logic [3:0] gv;
  logic signed [CUR_W-1:0] lo_cur;
  logic signed [CUR_W-1:0] hi_cur;

  assign gv     = {gate_sa1, gate_sa2, gate_sb1, gate_sb2};
  assign lo_cur = (cur_a < cur_b) ? cur_a : cur_b;
  assign hi_cur = (cur_a < cur_b) ? cur_b : cur_a;

  // R7: only the three legal patterns or all-off
  a_r7_legal_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (gv == 4'b0000) || (gv == 4'b0100) || (gv == 4'b1000) || (gv == 4'b0011));

  a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gv == 4'b0000) && (phase_q == 1'b0));

  a_r9_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !smp_vld) |=> $stable(gv));

  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == 1'b1) |=> $stable(mode_q));

  a_r3_mean_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (func_sel == 2'd0) |-> (ref_w >= lo_cur) && (ref_w <= hi_cur));

  a_r5_low_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (en && smp_vld && phase_q == 1'b0 && hit_lo) |=> (phase_q == 1'b1) && (gv == 4'b0011));

  a_r2_pick_a: assert property (@(posedge clk) disable iff (!rst_n)
    (en && smp_vld && phase_q == 1'b0 && cur_a > cur_b) |=> (mode_q == 1'b0));

  a_r2_pick_b: assert property (@(posedge clk) disable iff (!rst_n)
    (en && smp_vld && phase_q == 1'b0 && cur_b > cur_a) |=> (mode_q == 1'b1));
endmodule

bind hcc_gate_ctrl hcc_gate_ctrl_chk #(.CUR_W(CUR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .smp_vld  (smp_vld),
  .cur_a    (cur_a),
  .cur_b    (cur_b),
  .func_sel (func_sel),
  .ref_w    (ref_w),
  .hit_lo   (hit_lo),
  .mode_q   (mode_q),
  .phase_q  (phase_q),
  .gate_sa1 (gate_sa1),
  .gate_sa2 (gate_sa2),
  .gate_sb1 (gate_sb1),
  .gate_sb2 (gate_sb2)
);

// File: tb/hcc_gate_ctrl_tb.sv
`timescale 1ns/1ps
module hcc_gate_ctrl_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [W-1:0] cur_a = '0;
  logic signed [W-1:0] cur_b = '0;
  logic [1:0] func_sel = 2'd0;
  logic signed [W-1:0] ext_ref = '0;
  logic [W-1:0] band = '0;
  logic gate_sa1, gate_sa2, gate_sb1, gate_sb2;

  int checks = 0;
  int errors = 0;
  int m_mode = 0;   // 0 = A, 1 = B
  int m_ph = 0;     // 0 = charging, 1 = discharging
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  hcc_gate_ctrl #(.CUR_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_vld(smp_vld),
    .cur_a(cur_a), .cur_b(cur_b), .func_sel(func_sel), .ext_ref(ext_ref),
    .band(band), .gate_sa1(gate_sa1), .gate_sa2(gate_sa2),
    .gate_sb1(gate_sb1), .gate_sb2(gate_sb2)
  );

  function automatic logic [3:0] gates_now();
    return {gate_sa1, gate_sa2, gate_sb1, gate_sb2};
  endfunction

  function automatic int half_down(int s);
    if (s >= 0) return s / 2;
    return -((1 - s) / 2);
  endfunction

  function automatic logic [3:0] model_gates();
    if (m_ph == 1) return 4'b0011;
    return (m_mode == 0) ? 4'b0100 : 4'b1000;
  endfunction

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: gates got %b expected %b", req, got, exp);
    end
  endtask

  function automatic int rnd(int span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'h7fff) % span;
  endfunction

  task automatic step(input int ia, input int ib, input int fn, input int ex,
                      input int bd, input string req);
    int r;
    int c;
    @(negedge clk);
    cur_a = W'(ia); cur_b = W'(ib); func_sel = 2'(fn);
    ext_ref = W'(ex); band = W'(bd); smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    if (fn == 0) r = half_down(ia + ib);
    else if (fn == 1) r = ex;
    else r = 0;
    if (m_ph == 0) begin
      if (ia > ib) m_mode = 0;
      else if (ib > ia) m_mode = 1;
    end
    c = (m_mode == 0) ? ia : ib;
    if (m_ph == 0) begin
      if (c <= r - bd) m_ph = 1;
    end else begin
      if (c > r + bd) m_ph = 0;
    end
    check(req, gates_now(), model_gates());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", gates_now(), 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset, disabled", gates_now(), 4'b0000);
    en = 1'b1;

    // R1/R7: first strobe starts in charging, mode A
    step(10, 2, 0, 0, 1, "R1 R7 first strobe charging mode A");
    // R9: no strobe, gates hold
    repeat (3) @(negedge clk);
    check("R9 hold without strobe", gates_now(), 4'b0100);

    // R5: set-point drives charging into discharge
    step(3, 2, 1, 10, 1, "R5 low edge reached");
    // R6: inside band holds discharge; R8 mode frozen despite b > a
    step(2, 9, 1, 10, 1, "R6 R8 hold inside band");
    // R8: exit strobe keeps mode A
    step(20, 30, 1, 10, 1, "R8 exit uses held mode");
    // R2: next charging strobe re-picks mode B
    step(20, 30, 1, 10, 1, "R2 mode B picked");
    // R2: equal currents keep mode B
    step(5, 5, 1, 0, 0, "R2 equal keeps mode");

    // R4/R10: null ignores ext_ref and stays charging
    for (int k = 0; k < 6; k++)
      step(3 + k, 1, 2 + (k % 2), 50, 2, "R4 R10 null stays charging");

    // R1: disable from discharge clears gates and phase
    step(1, 0, 1, 20, 0, "R5 discharge before disable");
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    m_ph = 0;
    check("R1 disable clears gates", gates_now(), 4'b0000);
    // strobe while disabled has no effect
    @(negedge clk);
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    check("R1 strobe ignored while disabled", gates_now(), 4'b0000);
    en = 1'b1;
    step(4, 4, 1, 0, 0, "R1 R2 resume charging, mode kept");

    // R3/R5/R6: near-exhaustive balance sweep
    for (int bd = 0; bd < 4; bd++)
      for (int ia = -6; ia <= 6; ia++)
        for (int ib = -6; ib <= 6; ib++)
          step(ia, ib, 0, 0, bd, "R3 R5 R6 balance sweep");

    // R4/R7/R8: mixed sequence over every function
    for (int n = 0; n < 2000; n++)
      step(rnd(41) - 20, rnd(41) - 20, rnd(4), rnd(41) - 20, rnd(6),
           "R4 R7 R8 mixed sequence");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: run incomplete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule